// File: doc/BRIEF.md
# Digital/Analog Regulation Loop Handover Controller

This block decides which of two regulation loops drives the array of parallel pass-device units: a digital loop that switches whole units on and off, or an analog error-amplifier loop that drives the unit gates continuously. At light load the digital loop keeps control because it has a very low quiescent cost. At heavy load the amplifier takes over to suppress ripple. Outside a handover, only one loop is enabled.

A handover is started by the rising edge of a threshold flag. It passes through an overlap phase in which both loops run. The incoming loop is the master. The outgoing loop keeps running as a slave, with its reference lowered by a hysteresis offset. The outgoing loop is retired when the feedback-above-nominal flag for that direction is seen. A settle count must then expire before the new steady mode is declared, and no new handover can start during that count. If an overlap does not reach its retire condition within a timeout, the controller falls back to the mode it started from and raises a sticky error flag. A per-unit selector routes each unit to digital drive while the digital loop is enabled and the unit's digital code bit is set. All other units go to the amplifier.

States:
- `ST_DIG`: digital steady mode.
- `ST_D2A_OVL`: overlap on the way to analog.
- `ST_D2A_SETL`: settle after the digital loop is retired.
- `ST_ANA`: analog steady mode.
- `ST_A2D_OVL`: overlap on the way to digital.
- `ST_A2D_SETL`: settle after the amplifier is retired.

Transitions:
- Upward trigger: DIG→D2A_OVL.
- Digital retire: D2A_OVL→D2A_SETL.
- Upward timeout: D2A_OVL→DIG.
- Analog declare: D2A_SETL→ANA.
- Downward trigger: ANA→A2D_OVL.
- Analog retire: A2D_OVL→A2D_SETL.
- Downward timeout: A2D_OVL→ANA.
- Digital declare: A2D_SETL→DIG.

Top module: `loop_handover_ctrl`

## Requirements
- R1: After reset the controller is in digital steady mode: `dig_en_o`=1, `amp_en_o`=0, both reference-offset selects are 0 and `err_o`=0.
- R2: In digital steady mode, a rising edge of `load_hi_i` moves the controller into overlap at the next clock edge. In overlap, `amp_en_o`=1, `dig_en_o`=1, `dig_ref_low_o`=1 and `amp_ref_low_o`=0. `load_lo_i` has no effect in digital steady mode.
- R3: In the upward overlap, `fb_up_i` high at a clock edge retires the digital loop. After that edge, `dig_en_o`=0, `amp_en_o`=1 and both offset selects are 0.
- R4: In analog steady mode, a rising edge of `load_lo_i` starts the downward overlap. In that overlap, both loops are enabled, `amp_ref_low_o`=1 and `dig_ref_low_o`=0. `fb_dn_i` high then retires the amplifier, leaving `dig_en_o`=1 and `amp_en_o`=0. `load_hi_i` has no effect in analog steady mode.
- R5: After a retire edge, the controller stays in a settle state for exactly SETTLE_CYC clock edges, and it ignores trigger edges during that time. The first edge at which a trigger is accepted is retire edge + SETTLE_CYC + 1.
- R6: An overlap that has not retired after TIMEOUT_CYC clock edges returns to its originating steady mode on edge entry + TIMEOUT_CYC, with both offset selects at 0.
- R7: `err_o` is set by a timeout and stays at 1 until reset. Later handovers do not clear it.
- R8: `unit_sel_o[i]` = 1 (unit i on digital drive) exactly when `dig_en_o`=1 and `dig_code_i[i]`=1. Otherwise `unit_sel_o[i]`=0 (unit i on the amplifier). Bit i maps to unit i.
- R9: At least one loop is always enabled. Each offset select is 1 only while both loops are enabled, and the two offset selects are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_hi_i | input | 1 | Sensed load current above the upper threshold |
| load_lo_i | input | 1 | Sensed load current below the lower threshold |
| fb_up_i | input | 1 | Feedback above nominal reference, used to retire the digital loop |
| fb_dn_i | input | 1 | Feedback above nominal reference, used to retire the amplifier |
| dig_code_i | input | N_UNITS | Thermometer code from the digital loop, one bit per unit |
| amp_en_o | output | 1 | Error amplifier enable |
| dig_en_o | output | 1 | Digital loop enable |
| dig_ref_low_o | output | 1 | Digital loop reference lowered by the hysteresis offset |
| amp_ref_low_o | output | 1 | Amplifier reference lowered by the hysteresis offset |
| unit_sel_o | output | N_UNITS | Per-unit route: 1 = digital drive, 0 = amplifier |
| err_o | output | 1 | Sticky handover-timeout flag |

## Verification
The assertions assume that all flags are synchronous to `clk` and stable across each edge. They also assume that a threshold flag is meaningful only at its rising edge, so holding a flag high never asks for a second handover. The stimulus changes every input just after a falling clock edge. It raises a trigger for one or more cycles and lowers it again before the next intended handover. It raises a feedback flag only during the overlap it belongs to, and only for one cycle.

// File: rtl/hov_pkg.sv
package hov_pkg;

    typedef enum logic [2:0] {
        ST_DIG      = 3'd0,
        ST_D2A_OVL  = 3'd1,
        ST_D2A_SETL = 3'd2,
        ST_ANA      = 3'd3,
        ST_A2D_OVL  = 3'd4,
        ST_A2D_SETL = 3'd5
    } hov_state_t;

    typedef struct packed {
        logic amp_en;
        logic dig_en;
        logic dig_ref_low;
        logic amp_ref_low;
    } loop_ctl_t;

endpackage

// File: rtl/edge_trigger.sv
module edge_trigger #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] lvl_i,
    output logic [N_FLAGS-1:0] rise_o
);

    logic [N_FLAGS-1:0] lvl_q;

    genvar g;
    generate
        for (g = 0; g < N_FLAGS; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lvl_q[g] <= 1'b0;
                else        lvl_q[g] <= lvl_i[g];
            end
            assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
        end
    endgenerate

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_o <= '0;
        else if (clear_i)          cnt_o <= '0;
        else if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/handover_fsm.sv
module handover_fsm
    import hov_pkg::*;
#(
    parameter int SETTLE_CYC  = 32,
    parameter int TIMEOUT_CYC = 1024,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_trig_i,
    input  logic             dn_trig_i,
    input  logic             fb_up_i,
    input  logic             fb_dn_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             restart_o,
    output loop_ctl_t        ctl_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    hov_state_t state_q, state_d;
    logic       tmo_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DIG;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_o   <= err_o | tmo_evt;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        tmo_evt = 1'b0;
        unique case (state_q)
            ST_DIG: begin
                if (up_trig_i) state_d = ST_D2A_OVL;
            end
            ST_D2A_OVL: begin
                if (fb_up_i) begin
                    state_d = ST_D2A_SETL;
                end else if (cnt_i == TIMEOUT_LAST) begin
                    state_d = ST_DIG;
                    tmo_evt = 1'b1;
                end
            end
            ST_D2A_SETL: begin
                if (cnt_i == SETTLE_LAST) state_d = ST_ANA;
            end
            ST_ANA: begin
                if (dn_trig_i) state_d = ST_A2D_OVL;
            end
            ST_A2D_OVL: begin
                if (fb_dn_i) begin
                    state_d = ST_A2D_SETL;
                end else if (cnt_i == TIMEOUT_LAST) begin
                    state_d = ST_ANA;
                    tmo_evt = 1'b1;
                end
            end
            ST_A2D_SETL: begin
                if (cnt_i == SETTLE_LAST) state_d = ST_DIG;
            end
            default: state_d = ST_DIG;
        endcase
    end

    assign restart_o = (state_d != state_q);

    // outputs
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_DIG:      ctl_o.dig_en = 1'b1;
            ST_D2A_OVL: begin
                ctl_o.amp_en      = 1'b1;
                ctl_o.dig_en      = 1'b1;
                ctl_o.dig_ref_low = 1'b1;
            end
            ST_D2A_SETL: ctl_o.amp_en = 1'b1;
            ST_ANA:      ctl_o.amp_en = 1'b1;
            ST_A2D_OVL: begin
                ctl_o.amp_en      = 1'b1;
                ctl_o.dig_en      = 1'b1;
                ctl_o.amp_ref_low = 1'b1;
            end
            ST_A2D_SETL: ctl_o.dig_en = 1'b1;
            default:     ctl_o.dig_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/unit_router.sv
module unit_router #(
    parameter int N_UNITS = 16
) (
    input  logic               dig_en_i,
    input  logic [N_UNITS-1:0] code_i,
    output logic [N_UNITS-1:0] sel_o
);

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            assign sel_o[u] = dig_en_i & code_i[u];
        end
    endgenerate

endmodule

// File: rtl/loop_handover_ctrl.sv
module loop_handover_ctrl
    import hov_pkg::*;
#(
    parameter int N_UNITS     = 16,
    parameter int SETTLE_CYC  = 32,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_hi_i,
    input  logic               load_lo_i,
    input  logic               fb_up_i,
    input  logic               fb_dn_i,
    input  logic [N_UNITS-1:0] dig_code_i,
    output logic               amp_en_o,
    output logic               dig_en_o,
    output logic               dig_ref_low_o,
    output logic               amp_ref_low_o,
    output logic [N_UNITS-1:0] unit_sel_o,
    output logic               err_o
);

    localparam int LONGEST = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [1:0]       rise;
    logic [CNT_W-1:0] cnt;
    logic             restart;
    loop_ctl_t        ctl;

    edge_trigger #(.N_FLAGS(2)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({load_lo_i, load_hi_i}),
        .rise_o(rise)
    );

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(restart),
        .cnt_o  (cnt)
    );

    handover_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_trig_i(rise[0]),
        .dn_trig_i(rise[1]),
        .fb_up_i  (fb_up_i),
        .fb_dn_i  (fb_dn_i),
        .cnt_i    (cnt),
        .restart_o(restart),
        .ctl_o    (ctl),
        .err_o    (err_o)
    );

    unit_router #(.N_UNITS(N_UNITS)) u_route (
        .dig_en_i(ctl.dig_en),
        .code_i  (dig_code_i),
        .sel_o   (unit_sel_o)
    );

    assign amp_en_o      = ctl.amp_en;
    assign dig_en_o      = ctl.dig_en;
    assign dig_ref_low_o = ctl.dig_ref_low;
    assign amp_ref_low_o = ctl.amp_ref_low;

endmodule

// File: rtl/handover_chk.sv
module handover_chk #(
    parameter int N_UNITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               amp_en_o,
    input logic               dig_en_o,
    input logic               dig_ref_low_o,
    input logic               amp_ref_low_o,
    input logic [N_UNITS-1:0] unit_sel_o,
    input logic               err_o
);

    // R9
    one_loop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_en_o || dig_en_o);

    // R9
    offset_in_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_ref_low_o || amp_ref_low_o) |-> (amp_en_o && dig_en_o));

    // R9
    single_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dig_ref_low_o && amp_ref_low_o));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R8
    route_needs_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_sel_o) |-> dig_en_o);

    // R2
    amp_entry_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_en_o) |-> dig_ref_low_o);

    // R3
    dig_exit_amp_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_en_o) |-> (amp_en_o && !amp_ref_low_o));

    // R6
    timeout_clears_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!dig_ref_low_o && !amp_ref_low_o));

endmodule

bind loop_handover_ctrl handover_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .amp_en_o     (amp_en_o),
    .dig_en_o     (dig_en_o),
    .dig_ref_low_o(dig_ref_low_o),
    .amp_ref_low_o(amp_ref_low_o),
    .unit_sel_o   (unit_sel_o),
    .err_o        (err_o)
);

// File: tb/sim_loop_handover_ctrl.sv
`timescale 1ns/1ps
module sim_loop_handover_ctrl;

    localparam int N  = 8;
    localparam int ST = 6;
    localparam int TO = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_hi = 1'b0, load_lo = 1'b0, fb_up = 1'b0, fb_dn = 1'b0;
    logic [N-1:0] code = '0;
    logic         amp_en, dig_en, dig_rl, amp_rl, err;
    logic [N-1:0] usel;
    int           n_chk = 0, n_err = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    loop_handover_ctrl #(.N_UNITS(N), .SETTLE_CYC(ST), .TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .load_hi_i(load_hi), .load_lo_i(load_lo),
        .fb_up_i(fb_up), .fb_dn_i(fb_dn), .dig_code_i(code),
        .amp_en_o(amp_en), .dig_en_o(dig_en), .dig_ref_low_o(dig_rl),
        .amp_ref_low_o(amp_rl), .unit_sel_o(usel), .err_o(err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctl_is(input string req, input logic a, input logic d,
                          input logic drl, input logic arl);
        check({req, " amp_en"}, 32'(amp_en), 32'(a));
        check({req, " dig_en"}, 32'(dig_en), 32'(d));
        check({req, " dig_ref_low"}, 32'(dig_rl), 32'(drl));
        check({req, " amp_ref_low"}, 32'(amp_rl), 32'(arl));
    endtask

    task automatic t_reset();
        ctl_is("R1 reset", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R1 err", 32'(err), 32'd0);
        check("R8 zero code", 32'(usel), 32'd0);
    endtask

    task automatic t_route_digital();
        code = 8'hA5; #1;
        check("R8 route a5", 32'(usel), 32'hA5);
        code = 8'h3C; #1;
        check("R8 route 3c", 32'(usel), 32'h3C);
    endtask

    task automatic t_lo_ignored_in_dig();
        load_lo = 1'b1; step(1); load_lo = 1'b0; step(1);
        ctl_is("R2 lo ignored", 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_up_handover();
        load_hi = 1'b1; step(1);
        ctl_is("R2 up overlap", 1'b1, 1'b1, 1'b1, 1'b0);
        check("R8 overlap route", 32'(usel), 32'h3C);
        load_hi = 1'b0; step(3);
        ctl_is("R2 overlap holds", 1'b1, 1'b1, 1'b1, 1'b0);
        fb_up = 1'b1; step(1); fb_up = 1'b0;
        ctl_is("R3 digital retired", 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 analog route", 32'(usel), 32'd0);
    endtask

    task automatic t_settle_window();
        step(ST - 1);
        load_lo = 1'b1; step(1); load_lo = 1'b0;
        ctl_is("R5 trigger in settle ignored", 1'b1, 1'b0, 1'b0, 1'b0);
        step(1);
        load_lo = 1'b1; step(1); load_lo = 1'b0;
        ctl_is("R5 R4 trigger after settle", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_down_timeout();
        step(TO - 1);
        ctl_is("R6 before timeout", 1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 err before", 32'(err), 32'd0);
        step(1);
        ctl_is("R6 back to analog", 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 err set", 32'(err), 32'd1);
    endtask

    task automatic t_hi_ignored_in_ana();
        load_hi = 1'b1; step(2); load_hi = 1'b0; step(1);
        ctl_is("R4 hi ignored", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_down_handover();
        load_lo = 1'b1; step(1); load_lo = 1'b0;
        ctl_is("R4 down overlap", 1'b1, 1'b1, 1'b0, 1'b1);
        fb_dn = 1'b1; step(1); fb_dn = 1'b0;
        ctl_is("R4 amp retired", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 err kept", 32'(err), 32'd1);
        step(ST + 1);
    endtask

    task automatic t_up_timeout();
        load_hi = 1'b1; step(1); load_hi = 1'b0;
        ctl_is("R2 second up overlap", 1'b1, 1'b1, 1'b1, 1'b0);
        step(TO);
        ctl_is("R6 back to digital", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 err still set", 32'(err), 32'd1);
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        check("R7 err cleared by reset", 32'(err), 32'd0);
        ctl_is("R1 after second reset", 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_route_digital();
        t_lo_ignored_in_dig();
        t_up_handover();
        t_settle_window();
        t_down_timeout();
        t_hi_ignored_in_ana();
        t_down_handover();
        t_up_timeout();
        t_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule